// File: doc/BRIEF.md
# Interleaved multiphase PWM generator

This block produces gate-enable signals for a converter built from several parallel power stages. All channels run at one switching frequency. Their turn-on instants are spread evenly across the shared period, so channel k starts k slots after channel 0. With the default ten channels, each slot is 36 degrees. Every channel gets the same on-time, and that on-time is set at run time by a duty word. An on window that runs past the end of the period continues into the next one. Because of this, at high duty several channels are on at once, and at any instant only a few are off.

One counter runs from 0 to NCH*SLOT-1 and sets the period for all channels. Each channel compares its own phase-shifted view of that count with the active duty count. A new duty value can be written at any time through a load strobe. It takes effect only when the period starts again, so no channel ever produces a cut-short or doubled pulse. A one-clock pulse marks the start of each period. Control logic can use it to sample or to time its own updates.

Top module: `ilpwm_top`

## Requirements
- R1: While rst is high, or while enable was low at the previous clock edge, every bit of gate_o and period_start_o is 0.
- R2: While enabled, the period is PERIOD = NCH*SLOT clocks (100 by default). period_start_o is high for exactly one clock per period, and successive pulses are PERIOD clocks apart.
- R3: With tick t counted from 0 at the period start, channel k (gate_o bit k) turns on at tick k*SLOT. With the defaults and duty 63, bit 6 is low at t=59 and high at t=60.
- R4: Each channel stays on for exactly the active duty count in ticks, and the window wraps across the period boundary. At duty 63, bit 0 falls between t=62 and t=63. At t=63, six channels are on. Bit 9 stays on until t=52 of the following period.
- R5: A loaded duty value larger than PERIOD (for example 120) is clamped to PERIOD.
- R6: An active duty of 0 keeps every gate_o bit low. An active duty of PERIOD keeps every bit high.
- R7: A value loaded while running takes effect only from the next period start. This includes a load in the clock where the count is PERIOD-1. The last load before a period start wins.
- R8: After enable rises, the counter restarts from zero. period_start_o is high one clock later, and the gates follow the duty loaded while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low forces outputs low and count to zero |
| duty_in | input | DW (7) | Requested on-time in ticks, 0..PERIOD (clamped above) |
| duty_load | input | 1 | Captures duty_in into the pending register |
| gate_o | output | NCH (10) | Per-channel gate enables, bit k for channel k |
| period_start_o | output | 1 | One-clock pulse at each period start |

## Verification
The testbench runs a behavioural model of the block, built from integer arithmetic, and compares its outputs with the design's on every clock. Faults in the counter or the duty register therefore show up within the clock edge where the outputs first differ:
- A counter that skips or wraps early moves the period-start pulse and every gate edge by the very next period.
- A duty register that updates at the wrong moment changes the on-time within the period of the load, rather than one period later.

Directed checks are placed at the exact ticks where a channel's edge must fall. These cover the 63-percent slot example, a window that wraps past the period boundary, a load in the last tick, clamping, and a restart after disable.

// File: rtl/ilpwm_pkg.sv
package ilpwm_pkg;

    localparam int DEF_CHANNELS = 10;
    localparam int DEF_SLOT_TICKS = 10;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } run_mode_e;

    function automatic run_mode_e pick_mode(input logic rst, input logic en);
        return (!rst && en) ? MODE_RUN : MODE_IDLE;
    endfunction

endpackage

// File: rtl/ilpwm_timebase.sv
module ilpwm_timebase #(
    parameter int PERIOD = 100,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [CW-1:0] cnt_o,
    output logic          first_o,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    assign first_o = (cnt_q == '0);
    assign last_o  = (cnt_q == CW'(PERIOD - 1));
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/ilpwm_duty_hold.sv
module ilpwm_duty_hold #(
    parameter int PERIOD = 100,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          boundary,
    input  logic          load,
    input  logic [DW-1:0] duty_in,
    output logic [DW-1:0] active_o
);
    localparam logic [DW-1:0] LIMIT = DW'(PERIOD);

    logic [DW-1:0] pend_q;
    logic [DW-1:0] pend_nxt;
    logic [DW-1:0] act_q;
    logic [DW-1:0] clamped;

    always_comb begin
        clamped  = (duty_in > LIMIT) ? LIMIT : duty_in;
        pend_nxt = load ? clamped : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (!run || boundary) begin
                act_q <= pend_nxt;
            end
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/ilpwm_phase_gate.sv
module ilpwm_phase_gate #(
    parameter int PERIOD = 100,
    parameter int CW = 7,
    parameter int DW = 7,
    parameter int OFFSET = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] active,
    output logic          gate_o
);
    logic [CW:0] phase;
    logic        on_now;
    logic        gate_q;

    generate
        if (OFFSET == 0) begin : g_origin
            assign phase = {1'b0, cnt};
        end else begin : g_shifted
            always_comb begin
                if (cnt >= CW'(OFFSET)) begin
                    phase = {1'b0, cnt} - (CW+1)'(OFFSET);
                end else begin
                    phase = {1'b0, cnt} + (CW+1)'(PERIOD - OFFSET);
                end
            end
        end
    endgenerate

    assign on_now = (phase < (CW+1)'(active));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= on_now;
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/ilpwm_top.sv
module ilpwm_top
    import ilpwm_pkg::*;
#(
    parameter int NCH = DEF_CHANNELS,
    parameter int SLOT = DEF_SLOT_TICKS,
    localparam int PERIOD = NCH * SLOT,
    localparam int CW = $clog2(PERIOD),
    localparam int DW = $clog2(PERIOD + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [DW-1:0]  duty_in,
    input  logic           duty_load,
    output logic [NCH-1:0] gate_o,
    output logic           period_start_o
);
    run_mode_e     mode;
    logic          run;
    logic [CW-1:0] cnt_w;
    logic          first_w;
    logic          last_w;
    logic [DW-1:0] duty_w;
    logic          pstart_q;

    assign mode = pick_mode(rst, enable);
    assign run  = (mode == MODE_RUN);

    ilpwm_timebase #(.PERIOD(PERIOD), .CW(CW)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .cnt_o  (cnt_w),
        .first_o(first_w),
        .last_o (last_w)
    );

    ilpwm_duty_hold #(.PERIOD(PERIOD), .DW(DW)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .boundary(last_w),
        .load    (duty_load),
        .duty_in (duty_in),
        .active_o(duty_w)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            ilpwm_phase_gate #(
                .PERIOD(PERIOD), .CW(CW), .DW(DW), .OFFSET(k * SLOT)
            ) u_gate (
                .clk   (clk),
                .rst   (rst),
                .run   (run),
                .cnt   (cnt_w),
                .active(duty_w),
                .gate_o(gate_o[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pstart_q <= 1'b0;
        end else begin
            pstart_q <= first_w;
        end
    end

    assign period_start_o = pstart_q;
endmodule

// File: rtl/ilpwm_checker.sv
module ilpwm_checker #(
    parameter int P = 100,
    parameter int N = 10,
    parameter int CW = 7,
    parameter int DW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [CW-1:0] cnt,
    input logic [DW-1:0] active,
    input logic [N-1:0]  gate,
    input logic          pstart
);
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0 && !pstart));

    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < (CW+1)'(P)));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == '0) |=> pstart);

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        pstart |=> !pstart);

    p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (active <= DW'(P)));

    p_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> (gate == '0));

    p_full_on_r6: assert property (@(posedge clk) disable iff (rst)
        (en && active == DW'(P)) |=> (gate == '1));

    p_duty_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != CW'(P - 1)) |=> $stable(active));
endmodule

bind ilpwm_top ilpwm_checker #(
    .P(PERIOD), .N(NCH), .CW(CW), .DW(DW)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (enable),
    .cnt   (cnt_w),
    .active(duty_w),
    .gate  (gate_o),
    .pstart(period_start_o)
);

// File: tb/ilpwm_top_test.sv
`timescale 1ns/1ps
module ilpwm_top_test;
    localparam int N = 10;
    localparam int M = 10;
    localparam int P = N * M;
    localparam int DW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [DW-1:0] duty_in = '0;
    logic          duty_load = 1'b0;
    logic [N-1:0]  gate_o;
    logic          period_start_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    int           m_cnt = 0, m_act = 0, m_sh = 0;
    logic [N-1:0] e_gate = '0;
    logic         e_ps = 1'b0;

    always #2 clk = ~clk;

    ilpwm_top uut (
        .clk(clk), .rst(rst), .enable(enable), .duty_in(duty_in),
        .duty_load(duty_load), .gate_o(gate_o), .period_start_o(period_start_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        int sh_n;
        if (rst) begin
            m_cnt = 0; m_act = 0; m_sh = 0; e_gate = '0; e_ps = 1'b0;
        end else begin
            sh_n = duty_load ? ((int'(duty_in) > P) ? P : int'(duty_in)) : m_sh;
            if (!enable) begin
                e_gate = '0; e_ps = 1'b0; m_cnt = 0; m_act = sh_n;
            end else begin
                for (int k = 0; k < N; k++)
                    e_gate[k] = ((((m_cnt - k * M) % P) + P) % P) < m_act;
                e_ps = (m_cnt == 0);
                if (m_cnt == P - 1) begin
                    m_cnt = 0; m_act = sh_n;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_sh = sh_n;
        end
    end

    always @(negedge clk) begin
        chk({cur_tag, " model gates"}, 64'(gate_o), 64'(e_gate));
        chk({cur_tag, " model start"}, 64'(period_start_o), 64'(e_ps));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start();
        forever begin
            @(negedge clk);
            if (period_start_o) break;
        end
    endtask

    task automatic load(input int v);
        duty_in = DW'(v);
        duty_load = 1'b1;
        tick(1);
        duty_load = 1'b0;
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    initial begin
        int gap;
        tick(3);
        chk("R1 reset gates", 64'(gate_o), 0);
        chk("R1 reset start", 64'(period_start_o), 0);
        rst = 1'b0;
        tick(2);
        chk("R1 disabled gates", 64'(gate_o), 0);

        cur_tag = "R3";
        load(63);
        enable = 1'b1;
        wait_start();
        gap = 0;
        do begin
            tick(1); gap++;
        end while (!period_start_o);
        chk("R2 period length", 64'(gap), P);

        tick(59);
        chk("R3 ch6 before slot", 64'(gate_o[6]), 0);
        tick(1);
        chk("R3 ch6 at slot", 64'(gate_o[6]), 1);
        cur_tag = "R4";
        tick(2);
        chk("R4 ch0 on at t62", 64'(gate_o[0]), 1);
        tick(1);
        chk("R4 ch0 off at t63", 64'(gate_o[0]), 0);
        chk("R4 six on at t63", 64'(ones(gate_o)), 6);
        tick(37 + 52);
        chk("R4 ch9 wrapped on t52", 64'(gate_o[9]), 1);
        tick(1);
        chk("R4 ch9 off t53", 64'(gate_o[9]), 0);

        cur_tag = "R7";
        load(20);
        tick(6);
        chk("R7 old duty kept t60", 64'(gate_o[0]), 1);
        wait_start();
        tick(19);
        chk("R7 new duty t19", 64'(gate_o[0]), 1);
        tick(1);
        chk("R7 new duty t20", 64'(gate_o[0]), 0);
        tick(78);
        load(40);
        tick(1);
        chk("R7 start after last-tick load", 64'(period_start_o), 1);
        tick(39);
        chk("R7 last-tick load t39", 64'(gate_o[0]), 1);
        tick(1);
        chk("R7 last-tick load t40", 64'(gate_o[0]), 0);

        cur_tag = "R5";
        load(120);
        wait_start();
        for (int i = 0; i < 5; i++) begin
            tick(17);
            chk("R5 clamped all on", 64'(gate_o), 64'({N{1'b1}}));
        end
        cur_tag = "R6";
        load(0);
        wait_start();
        tick(1);
        for (int i = 0; i < 5; i++) begin
            tick(13);
            chk("R6 zero duty all off", 64'(gate_o), 0);
        end
        load(P);
        wait_start();
        tick(3);
        chk("R6 full duty all on", 64'(gate_o), 64'({N{1'b1}}));

        cur_tag = "R8";
        tick(30);
        enable = 1'b0;
        tick(1);
        chk("R1 gates drop on disable", 64'(gate_o), 0);
        load(63);
        tick(4);
        enable = 1'b1;
        tick(1);
        chk("R8 restart pulse", 64'(period_start_o), 1);
        chk("R8 ch0 on at restart", 64'(gate_o[0]), 1);
        chk("R8 ch1 off at restart", 64'(gate_o[1]), 0);
        tick(150);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule